// File: doc/BRIEF.md
# Receive FIFO Host Request Controller

This block decides when a host may pull received frame bytes out of a receive FIFO. It follows each frame from its start-of-frame event to its end. It counts the bytes written into the FIFO and arms a transfer request once enough of the frame is present. In standard mode the threshold is 64 bytes. In the low-latency mode it is 12 bytes after the start-frame delimiter. While armed, the request follows the FIFO fill level directly. It drops in the same cycle the level reaches zero. A host read is qualified as valid only when it really removes a byte, so reading too early never underflows the FIFO.

An external address-recognition pin, active low, gates each frame before its first request. In match mode the pin must be seen low to keep the frame. In reject mode a low pin throws the frame away. A rejected frame is flushed from the FIFO and never raises a request. Collisions, overflow and short frames are handled the same way: the block flushes the frame and, where the frame is returned to the host, reports a one-cycle status event. The two control bits live in a small byte-wide register. Both bits clear on the hardware reset and on the software reset.

Top module: `rxreq_ctrl`

## Requirements
- R1: On `rst`, and on a `sw_rst` pulse, the control register reads 0x00. `xfer_req`, `fifo_flush` and `stat_valid` are low and any frame in progress is dropped.
- R2: A control write stores bit 0 (low-latency enable) and bit 1 (match mode). Bits 7:2 always read as zero.
- R3: In standard mode, `xfer_req` stays low until the 64th `rx_byte` strobe of the frame. From the cycle after that strobe it equals (fill_level != 0).
- R4: In low-latency mode the request arms from the cycle after the 12th `rx_byte` strobe.
- R5: Whenever `fill_level` is zero, `xfer_req` is low in that same cycle.
- R6: `data_valid` is high only when `host_rd` is high while the request is active. Reads before arming, or against an empty FIFO, give `data_valid` low, and nothing is popped.
- R7: In standard mode, a frame that ends before 64 bytes is a runt. It gets a `fifo_flush` pulse, no status and no request. In low-latency mode a short frame is kept, and the host must discard runts itself.
- R8: On a collision, a low-latency frame is flushed and reported with `stat_late_coll`=1. A standard frame that is still below threshold is flushed silently. A standard frame that is already armed is flushed and reported with `stat_late_coll`=1.
- R9: In match mode the frame is kept only if `ext_addr_n` was low in some cycle from frame start up to the arming (or end) cycle. Otherwise `fifo_flush` pulses and no request is raised.
- R10: In reject mode, `ext_addr_n` low within that same window flushes the frame without a request. A low pin after arming is ignored.
- R11: On `fifo_ovf` during a frame, `fifo_flush` and `stat_valid` pulse with `stat_ovf`=1 and the request drops. The rest of the frame is ignored up to `frm_end`, and the next frame is handled normally.
- R12: A kept frame ends with a `stat_valid` pulse that has both error flags clear. The request then stays active until the FIFO reads empty, after which the block goes idle.
- R13: The low-latency bit is captured at frame start. Changing it mid-frame does not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| sw_rst | input | 1 | Software reset pulse, same effect as rst |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control write data (bit0 low-latency, bit1 match mode) |
| cfg_rdata | output | 8 | Control register read value |
| frm_start | input | 1 | Start-frame delimiter seen, frame begins |
| rx_byte | input | 1 | One frame byte written into the FIFO |
| frm_end | input | 1 | Frame reception finished |
| frm_coll | input | 1 | Collision during reception |
| fifo_ovf | input | 1 | FIFO overflowed |
| fill_level | input | FILL_W | Bytes currently readable in the FIFO |
| ext_addr_n | input | 1 | External address pin, active low |
| host_rd | input | 1 | Host read strobe |
| xfer_req | output | 1 | Data-transfer request to the host |
| data_valid | output | 1 | Current host read returns real data; also the FIFO pop |
| fifo_flush | output | 1 | One-cycle pulse: discard the current frame |
| stat_valid | output | 1 | One-cycle frame status event |
| stat_ovf | output | 1 | Status: overflow |
| stat_late_coll | output | 1 | Status: frame aborted by a (late) collision |

## Verification
A wrong byte count or a mis-latched mode shows up as `xfer_req` rising one or more cycles away from the 12th or 64th strobe. The per-byte sweep therefore catches it on the first frame long enough to reach the threshold. A lost address decision or a stale accept flag shows up as a request on a frame that should have been flushed, or as a flush pulse one cycle after the arming edge. A state machine stuck in its drain or discard state keeps the request low, or high, after the FIFO empties. That is visible the cycle after the level reaches zero, or at the next frame's threshold.

// File: rtl/rxreq_pkg.sv
`timescale 1ns/1ps
package rxreq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_STREAM,
        ST_DRAIN,
        ST_DISCARD
    } rx_state_e;

    typedef struct packed {
        logic ll;
        logic mr;
    } rx_cfg_t;

    typedef struct packed {
        logic valid;
        logic ovf;
        logic late_coll;
    } rx_stat_t;

    localparam int CFG_LL_BIT = 0;
    localparam int CFG_MR_BIT = 1;

    function automatic logic addr_keep(input logic match_mode, input logic pin_seen);
        return match_mode ? pin_seen : !pin_seen;
    endfunction

    function automatic logic [7:0] cfg_pack(input rx_cfg_t c);
        logic [7:0] v;
        v = 8'h00;
        v[CFG_LL_BIT] = c.ll;
        v[CFG_MR_BIT] = c.mr;
        return v;
    endfunction

endpackage

// File: rtl/rxreq_cfg.sv
`timescale 1ns/1ps
module rxreq_cfg
    import rxreq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sw_rst,
    input  logic       we,
    input  logic [7:0] wdata,
    output rx_cfg_t    cfg,
    output logic [7:0] rdata
);

    rx_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst || sw_rst) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q.ll <= wdata[CFG_LL_BIT];
            cfg_q.mr <= wdata[CFG_MR_BIT];
        end
    end

    assign cfg   = cfg_q;
    assign rdata = cfg_pack(cfg_q);

endmodule

// File: rtl/rxreq_frame.sv
`timescale 1ns/1ps
module rxreq_frame
    import rxreq_pkg::*;
#(
    parameter int NORM_THR = 64,
    parameter int LL_THR   = 12,
    parameter int RUNT_LEN = 64
) (
    input  logic      clk,
    input  logic      rst,
    input  rx_cfg_t   cfg,
    input  logic      frm_start,
    input  logic      rx_byte,
    input  logic      frm_end,
    input  logic      frm_coll,
    input  logic      fifo_ovf,
    input  logic      fill_empty,
    input  logic      ext_addr_n,
    output rx_state_e st,
    output logic      frm_ll,
    output logic      flush,
    output rx_stat_t  stat
);

    localparam int SAT_I  = (NORM_THR > RUNT_LEN) ? NORM_THR : RUNT_LEN;
    localparam int CNT_W  = $clog2(SAT_I + 1);
    localparam logic [CNT_W-1:0] SAT_C  = CNT_W'(SAT_I);
    localparam logic [CNT_W-1:0] NORM_C = CNT_W'(NORM_THR);
    localparam logic [CNT_W-1:0] LL_C   = CNT_W'(LL_THR);
    localparam logic [CNT_W-1:0] RUNT_C = CNT_W'(RUNT_LEN);

    rx_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic             ll_q, seen_q;
    logic             flush_d, flush_q;
    rx_stat_t         stat_d, stat_q;

    logic [CNT_W-1:0] thr;
    logic             pin_hit;
    logic             keep;
    logic             short_frame;

    always_comb begin
        cnt_nx = cnt_q;
        if (rx_byte && (cnt_q != SAT_C)) begin
            cnt_nx = cnt_q + 1'b1;
        end
    end

    assign thr         = ll_q ? LL_C : NORM_C;
    assign pin_hit     = seen_q || !ext_addr_n;
    assign keep        = addr_keep(cfg.mr, pin_hit);
    assign short_frame = !ll_q && (cnt_nx < RUNT_C);

    always_comb begin
        st_d    = st_q;
        flush_d = 1'b0;
        stat_d  = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (frm_start) begin
                    st_d = ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                if (fifo_ovf) begin
                    flush_d = 1'b1;
                    stat_d  = '{valid: 1'b1, ovf: 1'b1, late_coll: 1'b0};
                    st_d    = ST_DISCARD;
                end else if (frm_coll) begin
                    flush_d = 1'b1;
                    stat_d  = '{valid: ll_q, ovf: 1'b0, late_coll: ll_q};
                    st_d    = ST_IDLE;
                end else if (frm_end) begin
                    if (short_frame || !keep) begin
                        flush_d = 1'b1;
                        st_d    = ST_IDLE;
                    end else begin
                        stat_d = '{valid: 1'b1, ovf: 1'b0, late_coll: 1'b0};
                        st_d   = ST_DRAIN;
                    end
                end else if (cnt_nx >= thr) begin
                    if (keep) begin
                        st_d = ST_STREAM;
                    end else begin
                        flush_d = 1'b1;
                        st_d    = ST_DISCARD;
                    end
                end
            end
            ST_STREAM: begin
                if (fifo_ovf) begin
                    flush_d = 1'b1;
                    stat_d  = '{valid: 1'b1, ovf: 1'b1, late_coll: 1'b0};
                    st_d    = ST_DISCARD;
                end else if (frm_coll) begin
                    flush_d = 1'b1;
                    stat_d  = '{valid: 1'b1, ovf: 1'b0, late_coll: 1'b1};
                    st_d    = ST_IDLE;
                end else if (frm_end) begin
                    stat_d = '{valid: 1'b1, ovf: 1'b0, late_coll: 1'b0};
                    st_d   = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (fill_empty) begin
                    st_d = ST_IDLE;
                end
            end
            ST_DISCARD: begin
                if (frm_end) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            ll_q    <= 1'b0;
            seen_q  <= 1'b0;
            flush_q <= 1'b0;
            stat_q  <= '0;
        end else begin
            st_q    <= st_d;
            flush_q <= flush_d;
            stat_q  <= stat_d;
            if (st_q == ST_IDLE) begin
                if (frm_start) begin
                    cnt_q  <= '0;
                    ll_q   <= cfg.ll;
                    seen_q <= !ext_addr_n;
                end
            end else if (st_q == ST_COLLECT) begin
                cnt_q <= cnt_nx;
                if (!ext_addr_n) begin
                    seen_q <= 1'b1;
                end
            end
        end
    end

    assign st     = st_q;
    assign frm_ll = ll_q;
    assign flush  = flush_q;
    assign stat   = stat_q;

endmodule

// File: rtl/rxreq_host.sv
`timescale 1ns/1ps
module rxreq_host
    import rxreq_pkg::*;
#(
    parameter int FILL_W = 8
) (
    input  rx_state_e         st,
    input  logic [FILL_W-1:0] fill_level,
    input  logic              host_rd,
    output logic              fill_empty,
    output logic              xfer_req,
    output logic              data_valid
);

    logic armed;

    assign fill_empty = (fill_level == '0);
    assign armed      = (st == ST_STREAM) || (st == ST_DRAIN);
    assign xfer_req   = armed && !fill_empty;
    assign data_valid = host_rd && xfer_req;

endmodule

// File: rtl/rxreq_ctrl.sv
`timescale 1ns/1ps
module rxreq_ctrl
    import rxreq_pkg::*;
#(
    parameter int FILL_W   = 8,
    parameter int NORM_THR = 64,
    parameter int LL_THR   = 12,
    parameter int RUNT_LEN = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_rst,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              frm_start,
    input  logic              rx_byte,
    input  logic              frm_end,
    input  logic              frm_coll,
    input  logic              fifo_ovf,
    input  logic [FILL_W-1:0] fill_level,
    input  logic              ext_addr_n,
    input  logic              host_rd,
    output logic              xfer_req,
    output logic              data_valid,
    output logic              fifo_flush,
    output logic              stat_valid,
    output logic              stat_ovf,
    output logic              stat_late_coll
);

    rx_cfg_t   cfg;
    rx_state_e st;
    rx_stat_t  stat;
    logic      frm_ll;
    logic      fill_empty;
    logic      any_rst;

    assign any_rst = rst || sw_rst;

    rxreq_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .sw_rst (sw_rst),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .cfg    (cfg),
        .rdata  (cfg_rdata)
    );

    rxreq_frame #(
        .NORM_THR (NORM_THR),
        .LL_THR   (LL_THR),
        .RUNT_LEN (RUNT_LEN)
    ) u_frame (
        .clk        (clk),
        .rst        (any_rst),
        .cfg        (cfg),
        .frm_start  (frm_start),
        .rx_byte    (rx_byte),
        .frm_end    (frm_end),
        .frm_coll   (frm_coll),
        .fifo_ovf   (fifo_ovf),
        .fill_empty (fill_empty),
        .ext_addr_n (ext_addr_n),
        .st         (st),
        .frm_ll     (frm_ll),
        .flush      (fifo_flush),
        .stat       (stat)
    );

    rxreq_host #(
        .FILL_W (FILL_W)
    ) u_host (
        .st         (st),
        .fill_level (fill_level),
        .host_rd    (host_rd),
        .fill_empty (fill_empty),
        .xfer_req   (xfer_req),
        .data_valid (data_valid)
    );

    assign stat_valid     = stat.valid;
    assign stat_ovf       = stat.ovf;
    assign stat_late_coll = stat.late_coll;

endmodule

// File: rtl/rxreq_chk.sv
`timescale 1ns/1ps
module rxreq_chk
    import rxreq_pkg::*;
#(
    parameter int NORM_THR = 64
) (
    input logic      clk,
    input logic      rst,
    input logic      sw_rst,
    input logic      cfg_we,
    input logic [7:0] cfg_wdata,
    input logic [7:0] cfg_rdata,
    input logic      frm_start,
    input logic      rx_byte,
    input logic      frm_coll,
    input logic      fifo_ovf,
    input logic      xfer_req,
    input logic      fifo_flush,
    input logic      stat_valid,
    input logic      stat_ovf,
    input logic      stat_late_coll,
    input rx_state_e st,
    input logic      frm_ll
);

    logic [15:0] byte_seen;

    always_ff @(posedge clk) begin
        if (rst || sw_rst) begin
            byte_seen <= '0;
        end else if ((st == ST_IDLE) && frm_start) begin
            byte_seen <= '0;
        end else if (rx_byte && ((st == ST_COLLECT) || (st == ST_STREAM))
                     && (byte_seen != 16'hFFFF)) begin
            byte_seen <= byte_seen + 1'b1;
        end
    end

    p_swrst_r1: assert property (@(posedge clk) disable iff (rst || sw_rst)
        $past(sw_rst) |-> (cfg_rdata == 8'h00) && !xfer_req && (st == ST_IDLE));

    p_cfg_wr_r2: assert property (@(posedge clk) disable iff (rst || sw_rst)
        cfg_we |=> (cfg_rdata == {6'b0, $past(cfg_wdata[1:0])}));

    p_norm_thr_r3: assert property (@(posedge clk) disable iff (rst || sw_rst)
        ((st == ST_STREAM) && !frm_ll) |-> (byte_seen >= 16'(NORM_THR)));

    p_flush_noreq_r7: assert property (@(posedge clk) disable iff (rst || sw_rst)
        fifo_flush |-> !xfer_req);

    p_stat_flags_r8: assert property (@(posedge clk) disable iff (rst || sw_rst)
        stat_valid |-> $onehot0({stat_ovf, stat_late_coll}));

    p_late_coll_r8: assert property (@(posedge clk) disable iff (rst || sw_rst)
        ((st == ST_STREAM) && frm_coll && !fifo_ovf) |=> (stat_valid && stat_late_coll && fifo_flush));

    p_ovf_r11: assert property (@(posedge clk) disable iff (rst || sw_rst)
        (((st == ST_STREAM) || (st == ST_COLLECT)) && fifo_ovf) |=> (fifo_flush && stat_valid && stat_ovf));

endmodule

bind rxreq_ctrl rxreq_chk #(
    .NORM_THR (NORM_THR)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .sw_rst         (sw_rst),
    .cfg_we         (cfg_we),
    .cfg_wdata      (cfg_wdata),
    .cfg_rdata      (cfg_rdata),
    .frm_start      (frm_start),
    .rx_byte        (rx_byte),
    .frm_coll       (frm_coll),
    .fifo_ovf       (fifo_ovf),
    .xfer_req       (xfer_req),
    .fifo_flush     (fifo_flush),
    .stat_valid     (stat_valid),
    .stat_ovf       (stat_ovf),
    .stat_late_coll (stat_late_coll),
    .st             (st),
    .frm_ll         (frm_ll)
);

// File: tb/rxreq_ctrl_bench.sv
`timescale 1ns/1ps
module rxreq_ctrl_bench;

    localparam int NT = 64;
    localparam int LT = 12;

    logic       clk = 1'b0;
    logic       rst, sw_rst, cfg_we;
    logic [7:0] cfg_wdata, cfg_rdata;
    logic       frm_start, rx_byte, frm_end, frm_coll, fifo_ovf;
    logic [7:0] fill_level;
    logic       ext_addr_n, host_rd;
    logic       xfer_req, data_valid, fifo_flush, stat_valid, stat_ovf, stat_late_coll;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rxreq_ctrl u_rxreq_ctrl (
        .clk            (clk),
        .rst            (rst),
        .sw_rst         (sw_rst),
        .cfg_we         (cfg_we),
        .cfg_wdata      (cfg_wdata),
        .cfg_rdata      (cfg_rdata),
        .frm_start      (frm_start),
        .rx_byte        (rx_byte),
        .frm_end        (frm_end),
        .frm_coll       (frm_coll),
        .fifo_ovf       (fifo_ovf),
        .fill_level     (fill_level),
        .ext_addr_n     (ext_addr_n),
        .host_rd        (host_rd),
        .xfer_req       (xfer_req),
        .data_valid     (data_valid),
        .fifo_flush     (fifo_flush),
        .stat_valid     (stat_valid),
        .stat_ovf       (stat_ovf),
        .stat_late_coll (stat_late_coll)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wcfg(input logic [7:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        cyc();
        cfg_we = 1'b0;
    endtask

    task automatic start(input logic [7:0] c);
        wcfg(c);
        fill_level = 8'd0;
        frm_start = 1'b1;
        cyc();
        frm_start = 1'b0;
    endtask

    task automatic send(input int n);
        for (int i = 0; i < n; i++) begin
            rx_byte = 1'b1;
            fill_level = fill_level + 8'd1;
            cyc();
        end
        rx_byte = 1'b0;
    endtask

    task automatic end_frame();
        frm_end = 1'b1;
        cyc();
        frm_end = 1'b0;
    endtask

    task automatic settle();
        fill_level = 8'd0;
        cyc();
        cyc();
    endtask

    task automatic run_frame(input int len, input bit ll);
        bit runt;
        runt = !ll && (len < NT);
        wcfg(ll ? 8'h01 : 8'h00);
        fill_level = 8'd0;
        frm_start = 1'b1;
        cyc();
        frm_start = 1'b0;
        // R6: a read before arming is not valid
        host_rd = 1'b1;
        fill_level = 8'd3;
        #1;
        chk("R6 early read", int'(data_valid), 0);
        host_rd = 1'b0;
        fill_level = 8'd0;
        for (int k = 1; k <= len; k++) begin
            rx_byte = 1'b1;
            fill_level = 8'(k);
            cyc();
            if (ll) chk("R4 ll arm", int'(xfer_req), int'(k >= LT));
            else    chk("R3 norm arm", int'(xfer_req), int'(k >= NT));
        end
        rx_byte = 1'b0;
        end_frame();
        chk("R7 runt flush", int'(fifo_flush), int'(runt));
        chk("R12 status", int'(stat_valid), int'(!runt));
        chk("R12 no ovf", int'(stat_ovf), 0);
        chk("R12 no coll", int'(stat_late_coll), 0);
        chk("R7 req after end", int'(xfer_req), int'(!runt));
        if (runt) begin
            settle();
        end else begin
            for (int i = len; i >= 1; i--) begin
                fill_level = 8'(i);
                host_rd = 1'b1;
                #1;
                chk("R6 drain read", int'(data_valid), 1);
                cyc();
            end
            fill_level = 8'd0;
            #1;
            chk("R5 empty req", int'(xfer_req), 0);
            chk("R6 empty read", int'(data_valid), 0);
            cyc();
            host_rd = 1'b0;
            fill_level = 8'd4;
            #1;
            chk("R12 idle after drain", int'(xfer_req), 0);
            fill_level = 8'd0;
            cyc();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sw_rst = 1'b0; cfg_we = 1'b0; cfg_wdata = 8'h00;
        frm_start = 1'b0; rx_byte = 1'b0; frm_end = 1'b0; frm_coll = 1'b0;
        fifo_ovf = 1'b0; fill_level = 8'd0; ext_addr_n = 1'b1; host_rd = 1'b0;
        repeat (4) cyc();
        rst = 1'b0;
        cyc();
        chk("R1 cfg reset", int'(cfg_rdata), 0);
        chk("R1 req reset", int'(xfer_req), 0);
        chk("R1 flush reset", int'(fifo_flush), 0);
        chk("R1 stat reset", int'(stat_valid), 0);

        // R2: only bits 0 and 1 hold
        wcfg(8'hFF);
        chk("R2 write ff", int'(cfg_rdata), 3);
        wcfg(8'hFE);
        chk("R2 write fe", int'(cfg_rdata), 2);
        wcfg(8'h00);
        chk("R2 write 00", int'(cfg_rdata), 0);
        wcfg(8'h02);
        sw_rst = 1'b1; cyc(); sw_rst = 1'b0;
        chk("R1 sw reset cfg", int'(cfg_rdata), 0);

        // R3 R4 R7 R12: length sweep in both modes, reject mode with pin idle
        for (int m = 0; m < 2; m++) begin
            for (int len = 1; len <= 70; len++) begin
                run_frame(len, bit'(m));
            end
        end

        // R8: collisions
        start(8'h01); send(5);
        frm_coll = 1'b1; cyc(); frm_coll = 1'b0;
        chk("R8 ll coll flush", int'(fifo_flush), 1);
        chk("R8 ll coll stat", int'(stat_valid), 1);
        chk("R8 ll coll late", int'(stat_late_coll), 1);
        settle();
        start(8'h00); send(5);
        frm_coll = 1'b1; cyc(); frm_coll = 1'b0;
        chk("R8 early coll flush", int'(fifo_flush), 1);
        chk("R8 early coll silent", int'(stat_valid), 0);
        settle();
        start(8'h00); send(NT);
        chk("R8 armed before coll", int'(xfer_req), 1);
        frm_coll = 1'b1; cyc(); frm_coll = 1'b0;
        chk("R8 armed coll flush", int'(fifo_flush), 1);
        chk("R8 armed coll late", int'(stat_late_coll), 1);
        chk("R8 armed coll req", int'(xfer_req), 0);
        settle();

        // R9: match mode
        start(8'h03); send(LT);
        chk("R9 no match flush", int'(fifo_flush), 1);
        chk("R9 no match req", int'(xfer_req), 0);
        end_frame();
        chk("R9 no match status", int'(stat_valid), 0);
        settle();
        start(8'h03); send(2);
        ext_addr_n = 1'b0; send(1); ext_addr_n = 1'b1;
        send(LT - 3);
        chk("R9 match req", int'(xfer_req), 1);
        chk("R9 match no flush", int'(fifo_flush), 0);
        end_frame(); settle();

        // R10: reject mode
        start(8'h01); send(2);
        ext_addr_n = 1'b0; send(1); ext_addr_n = 1'b1;
        send(LT - 3);
        chk("R10 reject flush", int'(fifo_flush), 1);
        chk("R10 reject req", int'(xfer_req), 0);
        end_frame(); settle();
        start(8'h01); send(LT + 1);
        ext_addr_n = 1'b0; send(1); ext_addr_n = 1'b1;
        chk("R10 late pin req", int'(xfer_req), 1);
        chk("R10 late pin flush", int'(fifo_flush), 0);
        end_frame(); settle();

        // R11: overflow and recovery
        start(8'h01); send(20);
        fifo_ovf = 1'b1; cyc(); fifo_ovf = 1'b0;
        chk("R11 ovf flush", int'(fifo_flush), 1);
        chk("R11 ovf stat", int'(stat_valid), 1);
        chk("R11 ovf flag", int'(stat_ovf), 1);
        chk("R11 ovf req", int'(xfer_req), 0);
        send(3);
        chk("R11 discard req", int'(xfer_req), 0);
        end_frame();
        chk("R11 discard end", int'(stat_valid), 0);
        settle();
        start(8'h01); send(LT);
        chk("R11 recovery req", int'(xfer_req), 1);
        end_frame(); settle();

        // R13: mode captured at frame start
        start(8'h00); wcfg(8'h01); send(20);
        chk("R13 held normal", int'(xfer_req), 0);
        end_frame();
        chk("R13 runt flush", int'(fifo_flush), 1);
        settle();
        start(8'h01); wcfg(8'h00); send(LT);
        chk("R13 held ll", int'(xfer_req), 1);
        end_frame(); settle();

        // R1: software reset mid-frame
        start(8'h01); send(15);
        sw_rst = 1'b1; cyc(); sw_rst = 1'b0;
        chk("R1 sw reset req", int'(xfer_req), 0);
        chk("R1 sw reset cfg mid", int'(cfg_rdata), 0);
        settle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule